// File: doc/BRIEF.md
# GPIO Controller with Interrupt Shaping

This block is a register-mapped general-purpose I/O controller with 32-bit registers. Software sets the direction and output value of each pin, reads back the pin states, and uses two write-one ports to set or clear output bits without a read-modify-write. Every input pin passes through a two-stage synchronizer before anything else in the block uses it.

The low `NUM_IRQ` pins each drive one active-high interrupt line toward a parent interrupt controller. A line can follow its pin directly or follow the inverted pin. The output-data bit of that pin selects the inversion. A separate mode bit turns the line into a generator of one-cycle pulses on every transition of the pin. Edge or level latching, masking and end-of-interrupt handling are left to the parent controller.

Top module: `gpioc_top`

## Requirements
- R1: After reset the direction, output-data and interrupt-mode registers read 0, and `pin_oe`, `pin_out` and `irq` are all 0.
- R2: The direction register at byte offset 0x00 is readable and writable. `pin_oe` equals its low `NUM_PINS` bits, and a 1 marks a pin as an output.
- R3: The output-data register at offset 0x10 is readable and writable, and `pin_out` equals its low `NUM_PINS` bits.
- R4: A write to offset 0x18 sets each output-data bit whose write bit is 1 and leaves the other bits unchanged. Reading 0x18 returns 0.
- R5: A write to offset 0x20 clears each output-data bit whose write bit is 1 and leaves the other bits unchanged. Reading 0x20 returns 0.
- R6: Offset 0x08 reads the pins after a two-flop synchronizer. Writes to 0x08 change no register.
- R7: When a line's mode bit is 0 and its output-data bit is 0, `irq[i]` equals pin `i`. A pin change made before clock edge 1 appears on `irq[i]` after edge 3.
- R8: When the mode bit is 0 and the output-data bit is 1, `irq[i]` equals the inverted pin, with the same three-edge latency.
- R9: When the mode bit is 1 (interrupt-mode register at 0x30), each rising or falling pin transition gives exactly one cycle high on `irq[i]`, whatever the output-data bit holds. A stable pin leaves the line low.
- R10: Only the low `NUM_IRQ` interrupt-mode bits are stored, and the upper bits read 0. Reads of unmapped offsets return 0, and writes to them change no register.
- R11: `rdata` carries the addressed register in the cycle after `rd_en` is high, and is 0 in other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq | output | NUM_IRQ | Active-high interrupt lines |

## Verification
The bench uses the default build: 32 pins, of which the low 16 carry interrupt lines. With this build, a write of all ones to the interrupt-mode register shows the cut at bit 16. A full-width pin pattern shows every input and output bit. The interrupt tests run on one line and walk it through pass-through, inverted and both-edge modes. They sample the line one edge before and one edge after the expected change, so the three-edge latency is pinned exactly.

// File: rtl/gpioc_pkg.sv
`timescale 1ns/1ps
package gpioc_pkg;
    localparam int REG_W = 32;

    localparam logic [7:0] OFS_DIR  = 8'h00;
    localparam logic [7:0] OFS_IN   = 8'h08;
    localparam logic [7:0] OFS_OUT  = 8'h10;
    localparam logic [7:0] OFS_SET  = 8'h18;
    localparam logic [7:0] OFS_CLR  = 8'h20;
    localparam logic [7:0] OFS_MODE = 8'h30;

    typedef struct packed {
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] odat;
        logic [REG_W-1:0] mode;
        logic [REG_W-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/gpioc_sync.sv
`timescale 1ns/1ps
module gpioc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/gpioc_irq_shape.sv
`timescale 1ns/1ps
module gpioc_irq_shape #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] inv_i,
    input  logic [N-1:0] mode_i,
    output logic [N-1:0] irq_o
);
    logic [N-1:0] prev_d, prev_q, irq_d, irq_q;

    assign prev_d = sync_i;

    for (genvar gi = 0; gi < N; gi++) begin : g_line
        always_comb begin
            if (mode_i[gi])
                irq_d[gi] = sync_i[gi] ^ prev_q[gi];
            else
                irq_d[gi] = sync_i[gi] ^ inv_i[gi];
        end

        // R9
        edge_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mode_i[gi] && irq_q[gi] && (sync_i[gi] == prev_q[gi]) |=> !irq_q[gi]);

        // R7 R8
        level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_i[gi] && !$past(mode_i[gi]) && $stable(sync_i[gi]) && $stable(inv_i[gi])
            |=> $stable(irq_q[gi]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            irq_q  <= '0;
        end else begin
            prev_q <= prev_d;
            irq_q  <= irq_d;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/gpioc_top.sv
`timescale 1ns/1ps
module gpioc_top
    import gpioc_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int NUM_IRQ  = 16,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_IRQ-1:0]  irq
);
    localparam logic [REG_W-1:0] PIN_MASK = REG_W'((64'd1 << NUM_PINS) - 64'd1);
    localparam logic [REG_W-1:0] IRQ_MASK = REG_W'((64'd1 << NUM_IRQ) - 64'd1);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

    regs_t r_d, r_q;
    logic [NUM_PINS-1:0] pin_sync;

    gpioc_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rdata = '0;
        if (wr_en) begin
            case (addr)
                A_DIR:   r_d.dir  = wdata & PIN_MASK;
                A_OUT:   r_d.odat = wdata & PIN_MASK;
                A_SET:   r_d.odat = r_q.odat | (wdata & PIN_MASK);
                A_CLR:   r_d.odat = r_q.odat & ~wdata;
                A_MODE:  r_d.mode = wdata & IRQ_MASK;
                default: ;
            endcase
        end
        if (rd_en) begin
            case (addr)
                A_DIR:   r_d.rdata = r_q.dir;
                A_IN:    r_d.rdata = REG_W'(pin_sync);
                A_OUT:   r_d.rdata = r_q.odat;
                A_MODE:  r_d.rdata = r_q.mode;
                default: r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    gpioc_irq_shape #(.N(NUM_IRQ)) u_shape (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (pin_sync[NUM_IRQ-1:0]),
        .inv_i  (r_q.odat[NUM_IRQ-1:0]),
        .mode_i (r_q.mode[NUM_IRQ-1:0]),
        .irq_o  (irq)
    );

    assign rdata   = r_q.rdata;
    assign pin_out = r_q.odat[NUM_PINS-1:0];
    assign pin_oe  = r_q.dir[NUM_PINS-1:0];

    // R2
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_DIR |=> pin_oe == $past(wdata[NUM_PINS-1:0]));

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_SET |=>
        (pin_out & $past(wdata[NUM_PINS-1:0])) == $past(wdata[NUM_PINS-1:0]));

    // R5
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_CLR |=> (pin_out & $past(wdata[NUM_PINS-1:0])) == '0);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr != A_DIR && addr != A_IN && addr != A_OUT && addr != A_MODE
        |=> rdata == '0);

    // R11
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);
endmodule

// File: tb/gpioc_top_tb_top.sv
`timescale 1ns/1ps
module gpioc_top_tb_top;
    localparam int NP = 32;
    localparam int NI = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic [NI-1:0] irq;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;

    always #2.5 clk = ~clk;

    gpioc_top #(.NUM_PINS(NP), .NUM_IRQ(NI), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    // monitor: pops expected read data one cycle after each read strobe
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) check("R11 unexpected read", rdata, 32'h0);
            else check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_pin3(input logic v);
        @(negedge clk);
        pin_in[3] = v;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 pin_out", 32'(pin_out), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        bus_read(8'h00, 32'h0, "R1 dir reset");
        bus_read(8'h10, 32'h0, "R1 odat reset");
        bus_read(8'h30, 32'h0, "R1 mode reset");
        check("R11 idle rdata", rdata, 32'h0);

        // R2
        bus_write(8'h00, 32'hA5A5_0F0F);
        bus_read(8'h00, 32'hA5A5_0F0F, "R2 dir readback");
        @(negedge clk);
        check("R2 pin_oe", 32'(pin_oe), 32'hA5A5_0F0F);

        // R3
        bus_write(8'h10, 32'h1234_5678);
        bus_read(8'h10, 32'h1234_5678, "R3 odat readback");
        @(negedge clk);
        check("R3 pin_out", 32'(pin_out), 32'h1234_5678);

        // R4
        bus_write(8'h18, 32'h0000_00F0);
        bus_read(8'h10, 32'h1234_56F8, "R4 set result");
        bus_read(8'h18, 32'h0, "R4 set reads zero");

        // R5
        bus_write(8'h20, 32'h1200_0008);
        bus_read(8'h10, 32'h0034_56F0, "R5 clear result");
        bus_read(8'h20, 32'h0, "R5 clear reads zero");

        // R6
        @(negedge clk); pin_in = 32'hDEAD_BEEF;
        edges(3);
        bus_read(8'h08, 32'hDEAD_BEEF, "R6 input read");
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, 32'hDEAD_BEEF, "R6 input write ignored");
        bus_read(8'h10, 32'h0034_56F0, "R6 odat untouched");

        // R10
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, 32'h0, "R10 unmapped 04");
        bus_read(8'h28, 32'h0, "R10 unmapped 28");
        bus_read(8'h00, 32'hA5A5_0F0F, "R10 unmapped write no effect");
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_read(8'h30, 32'h0000_FFFF, "R10 mode width");

        // R7: pass-through
        bus_write(8'h30, 32'h0);
        bus_write(8'h10, 32'h0);
        @(negedge clk); pin_in = '0;
        edges(5);
        check("R7 idle low", 32'(irq), 32'h0);
        set_pin3(1'b1);
        edges(2);
        check("R7 latency before", 32'(irq[3]), 32'h0);
        edges(1);
        check("R7 follows pin", 32'(irq[3]), 32'h1);
        edges(3);
        check("R7 level held", 32'(irq[3]), 32'h1);

        // R8: inverted
        bus_write(8'h18, 32'h0000_0008);
        edges(2);
        check("R8 inverted high pin", 32'(irq[3]), 32'h0);
        set_pin3(1'b0);
        edges(2);
        check("R8 latency before", 32'(irq[3]), 32'h0);
        edges(1);
        check("R8 inverted low pin", 32'(irq[3]), 32'h1);

        // R9: both edges, output bit left at 1
        bus_write(8'h30, 32'h0000_0008);
        edges(3);
        check("R9 stable pin no pulse", 32'(irq[3]), 32'h0);
        set_pin3(1'b1);
        edges(2);
        check("R9 rise before", 32'(irq[3]), 32'h0);
        edges(1);
        check("R9 rise pulse", 32'(irq[3]), 32'h1);
        edges(1);
        check("R9 rise pulse one cycle", 32'(irq[3]), 32'h0);
        set_pin3(1'b0);
        edges(3);
        check("R9 fall pulse", 32'(irq[3]), 32'h1);
        edges(1);
        check("R9 fall pulse one cycle", 32'(irq[3]), 32'h0);
        edges(4);
        check("R9 quiet after", 32'(irq), 32'h0);

        edges(3);
        if (exp_q.size() != 0) check("R11 reads drained", 32'(exp_q.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule